// File: doc/BRIEF.md
# Payload Source Request Walker

This block turns the fields of one accepted payload descriptor into the ordered list of source read requests (address plus byte length) a fetch engine must issue. A start pulse captures the control word, the total byte count, the packed line size/stride word, the fragment base words and the address extension words. The block then presents one request at a time on a valid/ready handshake. Memory access and data buffering belong to the logic downstream.

Two walk styles exist. The line walk reads one line per request. After each request it steps the address by a scaled stride. The page walk visits up to five independently placed fragments. Each fragment is read from its start address up to the next 4 KiB page edge, and never past the bytes still owed. A level `done_o` marks the end of the walk. A read-error input aborts the walk at once and sets a channel-specific status bit.

Top module: `sas_source_walker`

## Requirements
- R1: After reset `req_valid_o`, `done_o` and every bit of `err_stat_o` are 0.
- R2: Bit 18 of `ctrl_i` picks the walk style at start: 0 selects the line walk and 1 selects the page walk.
- R3: Line walk. The line size is `size_stride_i[17:0]` and the stride is `size_stride_i[31:18]` times 16. The first request starts at fragment address 0 and has length min(line size, total). Each accepted request adds the stride to the address and takes its length off the remaining count. The next length is min(line size, remaining).
- R4: Fragment address k is base word k (`base_i[32k+31:32k]`) plus an extension field. Fragments 0, 2 and 4 add bits 27:16 of extension word 0, 1 and 2 shifted left by 20. Fragments 1 and 3 add bits 11:0 of extension word 1 and 2 shifted left by 8. Extension word j is `ext_i[32j+31:32j]`.
- R5: Page walk. Request k goes to fragment address k with length min(4096 − (address mod 4096), remaining). The walk ends after the fifth fragment even if bytes remain.
- R6: When the remaining count reaches zero on an accepted request, `req_valid_o` falls and `done_o` rises on that same clock edge. No request ever has length 0.
- R7: While `req_valid_o` is high and `req_ready_i` is low, the request address and length hold unchanged on the next cycle.
- R8: A start with total size 0, or a line-walk start with line size 0, issues no request. `done_o` is high in the cycle after the start.
- R9: `rd_err_i` high during a walk ends it on that edge: `req_valid_o` goes 0, `done_o` goes 1, and `err_stat_o` becomes 1 << (12 + CHAN) with no other bit set. The next accepted start clears `err_stat_o` and `done_o`.
- R10: A start pulse while a walk is in progress is ignored. The walk in flight continues with its captured fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Capture descriptor fields and begin a walk (when idle) |
| ctrl_i | input | 32 | Descriptor control word; bit 18 selects the walk style |
| size_i | input | SIZE_W | Total payload bytes |
| size_stride_i | input | 32 | Packed line size [17:0] and stride/16 [31:18] |
| base_i | input | NFRAG*32 | Fragment base words, word k at [32k+31:32k] |
| ext_i | input | NEXT*32 | Address extension words, word j at [32j+31:32j] |
| req_ready_i | input | 1 | Downstream accepts the current request |
| rd_err_i | input | 1 | Read failure, aborts the walk |
| req_valid_o | output | 1 | A request is presented |
| req_addr_o | output | ADDR_W | Request source address |
| req_len_o | output | SIZE_W | Request length in bytes |
| done_o | output | 1 | Walk finished or aborted; held until the next start |
| err_stat_o | output | 32 | Status word, bit 12+CHAN set on abort |

## Verification
The bench builds the block with CHAN set to 3, so an abort must appear as bit 15 alone. This also shows that the status position follows the parameter and is not fixed at bit 12. NFRAG stays at five, which brings the five-fragment cut-off and both extension field placements (the shift-by-8 and shift-by-20 forms) within reach. The 44-bit address width lets the added extension bits show up above bit 31 of the sum without wrapping.

// File: rtl/sas_pkg.sv
package sas_pkg;
  typedef enum logic { WALK_LINES = 1'b0, WALK_PAGES = 1'b1 } walk_mode_e;

  localparam int MODE_BIT     = 18;
  localparam int LINE_W       = 18;
  localparam int STRIDE_LSB   = 18;
  localparam int STRIDE_W     = 14;
  localparam int STRIDE_SHIFT = 4;
  localparam int ERR_BASE     = 12;
endpackage

// File: rtl/sas_frag_addr.sv
module sas_frag_addr #(
  parameter int NFRAG  = 5,
  parameter int NEXT   = NFRAG / 2 + 1,
  parameter int ADDR_W = 44
) (
  input  logic [NFRAG*32-1:0]     base_i,
  input  logic [NEXT*32-1:0]      ext_i,
  output logic [NFRAG*ADDR_W-1:0] addr_o
);
  logic unused_ext;
  assign unused_ext = ^ext_i;

  for (genvar gi = 0; gi < NFRAG; gi++) begin : g_frag
    logic [ADDR_W-1:0] hi_part;
    if (gi % 2 == 1) begin : g_low_field
      localparam int WI = (gi + 1) / 2;
      assign hi_part = ADDR_W'({ext_i[WI*32 +: 12], 8'h00});
    end else begin : g_high_field
      localparam int WI = gi / 2;
      assign hi_part = ADDR_W'({ext_i[WI*32 + 16 +: 12], 20'h00000});
    end
    assign addr_o[gi*ADDR_W +: ADDR_W] = ADDR_W'(base_i[gi*32 +: 32]) + hi_part;
  end
endmodule

// File: rtl/sas_seq.sv
module sas_seq
  import sas_pkg::*;
#(
  parameter int NFRAG   = 5,
  parameter int ADDR_W  = 44,
  parameter int SIZE_W  = 32,
  parameter int PAGE_LG = 12,
  parameter int CHAN    = 0,
  parameter int STAT_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start_i,
  input  walk_mode_e               mode_i,
  input  logic [SIZE_W-1:0]        size_i,
  input  logic [LINE_W-1:0]        line_i,
  input  logic [LINE_W-1:0]        stride_i,
  input  logic [NFRAG*ADDR_W-1:0]  frag_addr_i,
  input  logic                     req_ready_i,
  input  logic                     rd_err_i,
  output logic                     req_valid_o,
  output logic [ADDR_W-1:0]        req_addr_o,
  output logic [SIZE_W-1:0]        req_len_o,
  output logic                     done_o,
  output logic [STAT_W-1:0]        err_stat_o
);
  localparam int IDX_W   = (NFRAG > 1) ? $clog2(NFRAG) : 1;
  localparam int ERR_POS = ERR_BASE + CHAN;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NFRAG - 1);
  localparam logic [SIZE_W-1:0] PAGE_BYTES = SIZE_W'(1 << PAGE_LG);

  function automatic logic [SIZE_W-1:0] clip(input logic [SIZE_W-1:0] a,
                                             input logic [SIZE_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [SIZE_W-1:0] page_left(input logic [ADDR_W-1:0] a);
    return PAGE_BYTES - SIZE_W'(a[PAGE_LG-1:0]);
  endfunction

  logic                    busy_q;
  walk_mode_e              mode_q;
  logic [SIZE_W-1:0]       rem_q;
  logic [SIZE_W-1:0]       line_q;
  logic [ADDR_W-1:0]       stride_q;
  logic [IDX_W-1:0]        idx_q;
  logic [NFRAG*ADDR_W-1:0] frag_q;
  logic                    valid_q;
  logic [ADDR_W-1:0]       addr_q;
  logic [SIZE_W-1:0]       len_q;
  logic                    done_q;
  logic [STAT_W-1:0]       stat_q;

  // first request, taken straight from the start-time fields
  logic [ADDR_W-1:0] first_addr;
  logic [SIZE_W-1:0] first_len;
  logic              empty_walk;

  always_comb begin
    first_addr = frag_addr_i[ADDR_W-1:0];
    if (mode_i == WALK_PAGES) first_len = clip(page_left(first_addr), size_i);
    else                      first_len = clip(SIZE_W'(line_i), size_i);
    empty_walk = (size_i == '0) || ((mode_i == WALK_LINES) && (line_i == '0));
  end

  // step to the following request after an accepted one
  logic [SIZE_W-1:0] rem_next;
  logic              is_last;
  logic [IDX_W-1:0]  idx_next;
  logic [ADDR_W-1:0] addr_next;
  logic [SIZE_W-1:0] len_next;

  always_comb begin
    rem_next = rem_q - len_q;
    is_last  = (rem_next == '0) || ((mode_q == WALK_PAGES) && (idx_q == IDX_LAST));
    idx_next = (idx_q == IDX_LAST) ? idx_q : idx_q + 1'b1;
    if (mode_q == WALK_PAGES) begin
      addr_next = frag_q[int'(idx_next)*ADDR_W +: ADDR_W];
      len_next  = clip(page_left(addr_next), rem_next);
    end else begin
      addr_next = addr_q + stride_q;
      len_next  = clip(line_q, rem_next);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      mode_q   <= WALK_LINES;
      rem_q    <= '0;
      line_q   <= '0;
      stride_q <= '0;
      idx_q    <= '0;
      frag_q   <= '0;
      valid_q  <= 1'b0;
      addr_q   <= '0;
      len_q    <= '0;
      done_q   <= 1'b0;
      stat_q   <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        mode_q   <= mode_i;
        rem_q    <= size_i;
        line_q   <= SIZE_W'(line_i);
        stride_q <= ADDR_W'(stride_i);
        idx_q    <= '0;
        frag_q   <= frag_addr_i;
        stat_q   <= '0;
        addr_q   <= first_addr;
        len_q    <= first_len;
        if (empty_walk) begin
          done_q  <= 1'b1;
          valid_q <= 1'b0;
        end else begin
          done_q  <= 1'b0;
          busy_q  <= 1'b1;
          valid_q <= 1'b1;
        end
      end
    end else if (rd_err_i) begin
      busy_q          <= 1'b0;
      valid_q         <= 1'b0;
      done_q          <= 1'b1;
      stat_q[ERR_POS] <= 1'b1;
    end else if (valid_q && req_ready_i) begin
      rem_q <= rem_next;
      if (is_last) begin
        busy_q  <= 1'b0;
        valid_q <= 1'b0;
        done_q  <= 1'b1;
      end else begin
        idx_q  <= idx_next;
        addr_q <= addr_next;
        len_q  <= len_next;
      end
    end
  end

  assign req_valid_o = valid_q;
  assign req_addr_o  = addr_q;
  assign req_len_o   = len_q;
  assign done_o      = done_q;
  assign err_stat_o  = stat_q;
endmodule

// File: rtl/sas_source_walker.sv
module sas_source_walker
  import sas_pkg::*;
#(
  parameter int NFRAG   = 5,
  parameter int NEXT    = NFRAG / 2 + 1,
  parameter int ADDR_W  = 44,
  parameter int SIZE_W  = 32,
  parameter int PAGE_LG = 12,
  parameter int CHAN    = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [31:0]         ctrl_i,
  input  logic [SIZE_W-1:0]   size_i,
  input  logic [31:0]         size_stride_i,
  input  logic [NFRAG*32-1:0] base_i,
  input  logic [NEXT*32-1:0]  ext_i,
  input  logic                req_ready_i,
  input  logic                rd_err_i,
  output logic                req_valid_o,
  output logic [ADDR_W-1:0]   req_addr_o,
  output logic [SIZE_W-1:0]   req_len_o,
  output logic                done_o,
  output logic [31:0]         err_stat_o
);
  logic [NFRAG*ADDR_W-1:0] frag_addr;
  walk_mode_e              mode;
  logic [LINE_W-1:0]       line_bytes;
  logic [LINE_W-1:0]       stride_bytes;
  logic                    unused_ctrl;

  assign mode         = walk_mode_e'(ctrl_i[MODE_BIT]);
  assign line_bytes   = size_stride_i[LINE_W-1:0];
  assign stride_bytes = {size_stride_i[STRIDE_LSB +: STRIDE_W], STRIDE_SHIFT'(0)};
  assign unused_ctrl  = ^{ctrl_i[31:MODE_BIT+1], ctrl_i[MODE_BIT-1:0]};

  sas_frag_addr #(
    .NFRAG (NFRAG),
    .NEXT  (NEXT),
    .ADDR_W(ADDR_W)
  ) u_frag_addr (
    .base_i(base_i),
    .ext_i (ext_i),
    .addr_o(frag_addr)
  );

  sas_seq #(
    .NFRAG  (NFRAG),
    .ADDR_W (ADDR_W),
    .SIZE_W (SIZE_W),
    .PAGE_LG(PAGE_LG),
    .CHAN   (CHAN),
    .STAT_W (32)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .mode_i     (mode),
    .size_i     (size_i),
    .line_i     (line_bytes),
    .stride_i   (stride_bytes),
    .frag_addr_i(frag_addr),
    .req_ready_i(req_ready_i),
    .rd_err_i   (rd_err_i),
    .req_valid_o(req_valid_o),
    .req_addr_o (req_addr_o),
    .req_len_o  (req_len_o),
    .done_o     (done_o),
    .err_stat_o (err_stat_o)
  );
endmodule

// File: rtl/sas_checker.sv
module sas_checker #(
  parameter int ADDR_W = 44,
  parameter int SIZE_W = 32,
  parameter int CHAN   = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              req_ready_i,
  input logic              rd_err_i,
  input logic              req_valid_o,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic [SIZE_W-1:0] req_len_o,
  input logic              done_o,
  input logic [31:0]       err_stat_o
);
  localparam logic [31:0] ERR_MASK = 32'(1) << (12 + CHAN);

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid_o && !req_ready_i && !rd_err_i) |=>
      (req_valid_o && $stable(req_addr_o) && $stable(req_len_o)));

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !req_valid_o);

  assert_nonzero_len_R6: assert property (@(posedge clk) disable iff (rst)
    req_valid_o |-> (req_len_o != '0));

  assert_abort_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid_o && rd_err_i) |=> (!req_valid_o && done_o && (err_stat_o == ERR_MASK)));

  assert_stat_bit_R9: assert property (@(posedge clk) disable iff (rst)
    (err_stat_o & ~ERR_MASK) == 32'h0);

  assert_busy_start_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid_o && start_i && !req_ready_i && !rd_err_i) |=> $stable(req_addr_o));
endmodule

bind sas_source_walker sas_checker #(
  .ADDR_W(ADDR_W),
  .SIZE_W(SIZE_W),
  .CHAN  (CHAN)
) u_sas_checker (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .req_ready_i(req_ready_i),
  .rd_err_i   (rd_err_i),
  .req_valid_o(req_valid_o),
  .req_addr_o (req_addr_o),
  .req_len_o  (req_len_o),
  .done_o     (done_o),
  .err_stat_o (err_stat_o)
);

// File: tb/test_sas_source_walker.sv
module test_sas_source_walker;
  localparam int NFRAG = 5;
  localparam int NEXT  = 3;
  localparam int AW    = 44;
  localparam int SW    = 32;
  localparam int CH    = 3;
  localparam logic [31:0] ERR_EXP = 32'h0000_8000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [31:0] ctrl_i = '0;
  logic [SW-1:0] size_i = '0;
  logic [31:0] size_stride_i = '0;
  logic [NFRAG*32-1:0] base_i = '0;
  logic [NEXT*32-1:0] ext_i = '0;
  logic req_ready_i = 1'b0;
  logic rd_err_i = 1'b0;
  logic req_valid_o;
  logic [AW-1:0] req_addr_o;
  logic [SW-1:0] req_len_o;
  logic done_o;
  logic [31:0] err_stat_o;

  int checks = 0;
  int errors = 0;
  logic [AW-1:0] got_addr [8];
  logic [SW-1:0] got_len [8];

  always #5 clk = ~clk;

  sas_source_walker #(.NFRAG(NFRAG), .NEXT(NEXT), .ADDR_W(AW), .SIZE_W(SW), .CHAN(CH))
  i_sas_source_walker (
    .clk(clk), .rst(rst), .start_i(start_i), .ctrl_i(ctrl_i), .size_i(size_i),
    .size_stride_i(size_stride_i), .base_i(base_i), .ext_i(ext_i),
    .req_ready_i(req_ready_i), .rd_err_i(rd_err_i), .req_valid_o(req_valid_o),
    .req_addr_o(req_addr_o), .req_len_o(req_len_o), .done_o(done_o),
    .err_stat_o(err_stat_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic start_walk(input logic pages, input logic [SW-1:0] sz,
                            input logic [31:0] ss);
    @(negedge clk);
    ctrl_i = pages ? 32'h0004_0000 : 32'h0;
    size_i = sz;
    size_stride_i = ss;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // collect accepted requests, checking hold under stall (R7)
  task automatic collect(input bit stall, output int n);
    int cyc = 0;
    bit hold = 1'b0;
    logic [AW-1:0] pa = '0;
    logic [SW-1:0] pl = '0;
    logic rdy;
    n = 0;
    while (1) begin
      if (hold)
        chk(req_valid_o && req_addr_o == pa && req_len_o == pl, "R7",
            64'(req_addr_o), 64'(pa));
      rdy = stall ? cyc[0] : 1'b1;
      req_ready_i = rdy;
      if (req_valid_o && rdy && n < 8) begin
        got_addr[n] = req_addr_o;
        got_len[n] = req_len_o;
        n++;
      end
      hold = req_valid_o && !rdy;
      pa = req_addr_o;
      pl = req_len_o;
      if (done_o) break;
      cyc++;
      if (cyc > 200) begin
        chk(1'b0, "R6 end of walk", 64'(cyc), 64'd0);
        break;
      end
      @(negedge clk);
    end
    req_ready_i = 1'b0;
  endtask

  task automatic t_reset;
    chk(!req_valid_o, "R1 valid", 64'(req_valid_o), 64'd0);
    chk(!done_o, "R1 done", 64'(done_o), 64'd0);
    chk(err_stat_o == '0, "R1 stat", 64'(err_stat_o), 64'd0);
  endtask

  task automatic line_setup;
    base_i = '0;
    ext_i = '0;
    base_i[31:0] = 32'h0001_0000;
    ext_i[31:0] = 32'h0003_0000;
  endtask

  task automatic t_lines(input bit stall, input logic [SW-1:0] sz,
                         input logic [SW-1:0] last_len);
    int n;
    line_setup();
    start_walk(1'b0, sz, (32'd10 << 18) | 32'd100);
    collect(stall, n);
    chk(n == 3, "R3 count", 64'(n), 64'd3);
    chk(got_addr[0] == 44'h310000, "R2 R3 addr0", 64'(got_addr[0]), 64'h310000);
    chk(got_addr[1] == 44'h3100A0, "R3 addr1", 64'(got_addr[1]), 64'h3100A0);
    chk(got_addr[2] == 44'h310140, "R3 addr2", 64'(got_addr[2]), 64'h310140);
    chk(got_len[0] == 100 && got_len[1] == 100, "R3 len", 64'(got_len[1]), 64'd100);
    chk(got_len[2] == last_len, "R3 last len", 64'(got_len[2]), 64'(last_len));
    chk(done_o && !req_valid_o, "R6 done", 64'(done_o), 64'd1);
  endtask

  task automatic t_pages;
    int n;
    base_i = '0;
    ext_i = '0;
    base_i[31:0] = 32'h0000_0F00;
    ext_i[31:0] = 32'h0001_0000;
    base_i[63:32] = 32'h2000_0000;
    ext_i[63:32] = 32'h0002_0010;
    base_i[95:64] = 32'h0000_0800;
    start_walk(1'b1, 32'd5352, 32'h0);
    collect(1'b0, n);
    chk(n == 3, "R5 count", 64'(n), 64'd3);
    chk(got_addr[0] == 44'h100F00, "R2 R4 frag0", 64'(got_addr[0]), 64'h100F00);
    chk(got_len[0] == 256, "R5 len0", 64'(got_len[0]), 64'd256);
    chk(got_addr[1] == 44'h2000_1000, "R4 frag1", 64'(got_addr[1]), 64'h20001000);
    chk(got_len[1] == 4096, "R5 len1", 64'(got_len[1]), 64'd4096);
    chk(got_addr[2] == 44'h200800, "R4 frag2", 64'(got_addr[2]), 64'h200800);
    chk(got_len[2] == 1000, "R5 clipped len2", 64'(got_len[2]), 64'd1000);
  endtask

  task automatic t_five;
    int n;
    base_i = '0;
    ext_i = '0;
    for (int k = 0; k < 5; k++) base_i[k*32 +: 32] = 32'h1000 * (k + 1) + 32'hF00;
    ext_i[95:64] = 32'h0001_0002;
    start_walk(1'b1, 32'd10000, 32'h0);
    collect(1'b1, n);
    chk(n == 5, "R5 five limit", 64'(n), 64'd5);
    chk(got_addr[3] == 44'h5100, "R4 frag3", 64'(got_addr[3]), 64'h5100);
    chk(got_len[3] == 3840, "R5 len3", 64'(got_len[3]), 64'd3840);
    chk(got_addr[4] == 44'h105F00, "R4 frag4", 64'(got_addr[4]), 64'h105F00);
    chk(got_len[4] == 256, "R5 len4", 64'(got_len[4]), 64'd256);
  endtask

  task automatic t_empty;
    line_setup();
    start_walk(1'b0, 32'd0, (32'd10 << 18) | 32'd100);
    chk(done_o && !req_valid_o, "R8 zero size", 64'(done_o), 64'd1);
    start_walk(1'b0, 32'd50, 32'd10 << 18);
    chk(done_o && !req_valid_o, "R8 zero line", 64'(req_valid_o), 64'd0);
  endtask

  task automatic t_abort;
    t_pages_fields();
    start_walk(1'b1, 32'd5352, 32'h0);
    req_ready_i = 1'b1;
    @(negedge clk);
    req_ready_i = 1'b0;
    rd_err_i = 1'b1;
    @(negedge clk);
    rd_err_i = 1'b0;
    chk(!req_valid_o && done_o, "R9 stop", 64'(req_valid_o), 64'd0);
    chk(err_stat_o == ERR_EXP, "R9 stat", 64'(err_stat_o), 64'(ERR_EXP));
    start_walk(1'b1, 32'd0, 32'h0);
    chk(err_stat_o == '0, "R9 clear", 64'(err_stat_o), 64'd0);
  endtask

  task automatic t_pages_fields;
    base_i = '0;
    ext_i = '0;
    base_i[31:0] = 32'h0000_0F00;
    ext_i[31:0] = 32'h0001_0000;
  endtask

  task automatic t_busy_start;
    int n;
    line_setup();
    start_walk(1'b0, 32'd300, (32'd10 << 18) | 32'd100);
    base_i[31:0] = 32'h0077_0000;
    size_i = 32'd40;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(req_valid_o && req_addr_o == 44'h310000, "R10 held", 64'(req_addr_o), 64'h310000);
    collect(1'b0, n);
    chk(n == 3 && got_addr[2] == 44'h310140, "R10 walk intact", 64'(got_addr[2]),
        64'h310140);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 64'd0, 64'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_lines(1'b0, 32'd250, 32'd50);
    t_lines(1'b1, 32'd300, 32'd100);
    t_pages();
    t_five();
    t_empty();
    t_abort();
    t_busy_start();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule